// File: doc/BRIEF.md
# Mode-Banked Register File with Program Counter

This block holds the sixteen registers a 32-bit processor core sees at any moment. Fifteen are data registers. Slot 15 packs the word-aligned program counter together with the condition flags, two interrupt-disable bits and a two-bit processor mode. The mode field selects which physical copies stand behind slots 8 to 14. Fast-interrupt mode swaps in a private set of seven registers. Interrupt mode and supervisor mode each swap in a private stack pointer (slot 13) and link register (slot 14). Slots 0 to 7 are common to every mode.

The core reads two registers per cycle and writes one. It also steps the program counter after each fetch, loads it on a branch, and on a branch-and-link stores the return address in the link register of the current mode. Writing slot 15 through the write port reloads the flags, the disable bits, the program counter and the mode at once. The core uses that write to switch modes. Exception sequencing, instruction fetch and flag computation all sit outside this block.

Top module: `mode_banked_rf`

## Requirements
- R1: Reset clears every data register, sets the mode to supervisor (3), sets both interrupt-disable bits, clears the flags and sets the program counter to 0, so slot 15 reads 32'h0C000003.
- R2: Both read ports are combinational on the stored state. Slot 15 reads as flags in [31:28], disable bits in [27:26], program counter in [25:2] and mode in [1:0]. A write in the same cycle is not visible until after the clock edge.
- R3: A write to slots 0 to 14 updates the copy selected by the current mode at the next clock edge.
- R4: Mode encoding is 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor. Slots 0 to 7 are one shared copy across all modes.
- R5: Fast-interrupt mode has private copies of slots 8 to 14. The other three modes share slots 8 to 12.
- R6: Interrupt mode and supervisor mode each have private slots 13 and 14. These are distinct from each other and from the user copy.
- R7: When fetch_adv is high and neither a branch nor a slot-15 write occurs, the program counter advances by one word and wraps from all ones to 0. The status bits do not change.
- R8: When br_en is high, the program counter loads br_target at the next edge. This takes priority over both fetch_adv and a slot-15 write.
- R9: When br_en and br_link are both high, slot 14 of the current mode receives the byte address of the next word, ((pc+1) mod 2^24) shifted left by 2 and zero-extended, using the program counter before the branch. If the write port targets that slot in the same cycle, the link value wins.
- R10: A write to slot 15 loads flags, disable bits, mode and program counter from the written word. It loses only the program counter field to a simultaneous branch.
- R11: The mode changes only on a slot-15 write. The new bank selection applies from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_sel | input | 4 | Read port A slot |
| rd_a_val | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Read port B slot |
| rd_b_val | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Write slot |
| wr_val | input | 32 | Write data |
| fetch_adv | input | 1 | Advance program counter one word |
| br_en | input | 1 | Load program counter from br_target |
| br_link | input | 1 | With br_en, store return address in slot 14 |
| br_target | input | 24 | Branch target word address |
| pc_word | output | 24 | Current program counter (word address) |
| cur_mode | output | 2 | Current processor mode |

## Verification
The bench first fills slots 0 to 14 with a distinct pattern in each of the four modes. It then reads back every slot in every mode. Shared slots show the last writer, while banked slots keep their own values, which separates a wrong bank mapping from a lost write. Directed cases follow for counter wrap, branch against fetch and branch against slot-15 write, and a link write colliding with a port write to the same slot. These isolate the priority order. A long random mix of writes, mode switches, fetches and branches is then compared every cycle against a model that tracks each mode's view separately. This catches sharing errors that appear only after specific mode sequences.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } cpu_mode_e;

  // user 0..14, fast-irq 8..14 at 15..21, irq 13/14 at 22/23, svc 13/14 at 24/25
  localparam int RF_SLOTS  = 26;
  localparam int RF_SLOT_W = $clog2(RF_SLOTS);

  function automatic logic [RF_SLOT_W-1:0] phys_slot(input logic [1:0] mode,
                                                     input logic [3:0] idx);
    logic [RF_SLOT_W-1:0] s;
    s = RF_SLOT_W'(idx);
    if (idx == 4'd15)
      s = '0;
    else if (idx >= 4'd8 && cpu_mode_e'(mode) == MODE_FIQ)
      s = RF_SLOT_W'(idx) + RF_SLOT_W'(7);
    else if (idx >= 4'd13 && cpu_mode_e'(mode) == MODE_IRQ)
      s = RF_SLOT_W'(idx) + RF_SLOT_W'(9);
    else if (idx >= 4'd13 && cpu_mode_e'(mode) == MODE_SVC)
      s = RF_SLOT_W'(idx) + RF_SLOT_W'(11);
    return s;
  endfunction

endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 26,
  localparam int AW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we0,
  input  logic [AW-1:0]     waddr0,
  input  logic [DATA_W-1:0] wdata0,
  input  logic              we1,
  input  logic [AW-1:0]     waddr1,
  input  logic [DATA_W-1:0] wdata1,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     rb,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [SLOTS];

  // port 1 (link) overrides port 0 on a collision
  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (!rst_n)
        mem[s] <= '0;
      else if (we1 && waddr1 == AW'(s))
        mem[s] <= wdata1;
      else if (we0 && waddr0 == AW'(s))
        mem[s] <= wdata0;
    end
  end

  assign rdata_a = mem[ra];
  assign rdata_b = mem[rb];

  wire collide = we0 && we1 && (waddr0 == waddr1);

  // R3: port write lands in the addressed slot
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && !collide) |=> (mem[$past(waddr0)] == $past(wdata0)));

  // R9: link write lands and wins any collision
  a_r9_link_wins: assert property (@(posedge clk) disable iff (!rst_n)
    we1 |=> (mem[$past(waddr1)] == $past(wdata1)));

endmodule

// File: rtl/rf_psr.sv
module rf_psr import rf_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int PC_W  = DATA_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_adv,
  input  logic              br_en,
  input  logic [PC_W-1:0]   br_target,
  input  logic              st_we,
  input  logic [DATA_W-1:0] st_wdata,
  output logic [PC_W-1:0]   pc_o,
  output logic [3:0]        flags_o,
  output logic [1:0]        idis_o,
  output logic [1:0]        mode_o
);
  function automatic logic [PC_W-1:0] step_word(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  logic [PC_W-1:0] pc_q;
  logic [3:0]      flags_q;
  logic [1:0]      idis_q;
  logic [1:0]      mode_q;

  // R8 branch > R10 status write > R7 fetch step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      flags_q <= '0;
      idis_q  <= 2'b11;
      mode_q  <= MODE_SVC;
    end else begin
      if (br_en)          pc_q <= br_target;
      else if (st_we)     pc_q <= st_wdata[PC_W+1:2];
      else if (fetch_adv) pc_q <= step_word(pc_q);
      if (st_we) begin
        flags_q <= st_wdata[DATA_W-1 -: 4];
        idis_q  <= st_wdata[DATA_W-5 -: 2];
        mode_q  <= st_wdata[1:0];
      end
    end
  end

  assign pc_o    = pc_q;
  assign flags_o = flags_q;
  assign idis_o  = idis_q;
  assign mode_o  = mode_q;

  a_r7_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_adv && !br_en && !st_we) |=> (pc_q == $past(pc_q) + PC_W'(1)));

  a_r8_branch_load: assert property (@(posedge clk) disable iff (!rst_n)
    br_en |=> (pc_q == $past(br_target)));

  a_r10_status_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !br_en) |=> (pc_q == $past(st_wdata[PC_W+1:2]) && mode_q == $past(st_wdata[1:0])));

  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> ($stable(mode_q) && $stable(flags_q) && $stable(idis_q)));

endmodule

// File: rtl/mode_banked_rf.sv
module mode_banked_rf import rf_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int PC_W  = DATA_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_sel,
  output logic [DATA_W-1:0] rd_a_val,
  input  logic [3:0]        rd_b_sel,
  output logic [DATA_W-1:0] rd_b_val,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              fetch_adv,
  input  logic              br_en,
  input  logic              br_link,
  input  logic [PC_W-1:0]   br_target,
  output logic [PC_W-1:0]   pc_word,
  output logic [1:0]        cur_mode
);
  localparam logic [3:0] PC_SLOT   = 4'd15;
  localparam logic [3:0] LINK_SLOT = 4'd14;

  function automatic logic [DATA_W-1:0] link_word(input logic [PC_W-1:0] p);
    return {6'b0, p + PC_W'(1), 2'b00};
  endfunction

  logic [PC_W-1:0]      pc_q;
  logic [3:0]           flags;
  logic [1:0]           idis;
  logic [1:0]           mode;
  logic [DATA_W-1:0]    psr_word;
  logic [DATA_W-1:0]    ga, gb;
  logic [RF_SLOT_W-1:0] sa, sb, sw, sl;

  // named events for assertions
  wire wr_gpr    = wr_en && (wr_sel != PC_SLOT);
  wire wr_psr    = wr_en && (wr_sel == PC_SLOT);
  wire link_fire = br_en && br_link;

  assign sa = phys_slot(mode, rd_a_sel);
  assign sb = phys_slot(mode, rd_b_sel);
  assign sw = phys_slot(mode, wr_sel);
  assign sl = phys_slot(mode, LINK_SLOT);

  rf_store #(.DATA_W(DATA_W), .SLOTS(RF_SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we0(wr_gpr), .waddr0(sw), .wdata0(wr_val),
    .we1(link_fire), .waddr1(sl), .wdata1(link_word(pc_q)),
    .ra(sa), .rdata_a(ga), .rb(sb), .rdata_b(gb)
  );

  rf_psr #(.DATA_W(DATA_W)) u_psr (
    .clk(clk), .rst_n(rst_n),
    .fetch_adv(fetch_adv), .br_en(br_en), .br_target(br_target),
    .st_we(wr_psr), .st_wdata(wr_val),
    .pc_o(pc_q), .flags_o(flags), .idis_o(idis), .mode_o(mode)
  );

  assign psr_word = {flags, idis, pc_q, mode};
  assign rd_a_val = (rd_a_sel == PC_SLOT) ? psr_word : ga;
  assign rd_b_val = (rd_b_sel == PC_SLOT) ? psr_word : gb;
  assign pc_word  = pc_q;
  assign cur_mode = mode;

  // R2: slot 15 readback packs the live state
  a_r2_psr_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_sel == PC_SLOT) |-> (rd_a_val[PC_W+1:2] == pc_word && rd_a_val[1:0] == cur_mode));

  // R6: a banked link slot never aliases the user copy outside user mode
  a_r6_link_private: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fire && mode != MODE_USR) |-> (sl != RF_SLOT_W'(14)));

endmodule

// File: tb/sim_mode_banked_rf.sv
`timescale 1ns/1ps
module sim_mode_banked_rf;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  rd_a_sel = 0, rd_b_sel = 0, wr_sel = 0;
  logic [31:0] rd_a_val, rd_b_val, wr_val = 0;
  logic        wr_en = 0, fetch_adv = 0, br_en = 0, br_link = 0;
  logic [23:0] br_target = 0, pc_word;
  logic [1:0]  cur_mode;

  always #2 clk = ~clk;

  mode_banked_rf u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // independent model: one view per mode
  logic [31:0] view [4][15];
  logic [23:0] m_pc;
  logic [3:0]  m_flags;
  logic [1:0]  m_dis, m_mode;

  function automatic bit shares(input int a, input int b, input int idx);
    if (idx < 8) return 1;
    if (idx < 13) return (a == 1) == (b == 1);
    return a == b;
  endfunction

  function automatic logic [31:0] expect_rd(input logic [3:0] idx);
    if (idx == 4'd15) return {m_flags, m_dis, m_pc, m_mode};
    return view[m_mode][idx];
  endfunction

  task automatic put(input int md, input int idx, input logic [31:0] v);
    for (int k = 0; k < 4; k++) if (shares(md, k, idx)) view[k][idx] = v;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] ws, input logic [31:0] wv,
                      input logic fa, input logic br, input logic bl, input logic [23:0] tg,
                      input logic [3:0] ra, input logic [3:0] rb, input string req);
    logic [23:0] npc;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_val = wv; fetch_adv = fa;
    br_en = br; br_link = bl; br_target = tg; rd_a_sel = ra; rd_b_sel = rb;
    #1;
    check(req, rd_a_val, expect_rd(ra));
    check(req, rd_b_val, expect_rd(rb));
    check("R7", {8'h0, pc_word}, {8'h0, m_pc});
    check("R11", {30'h0, cur_mode}, {30'h0, m_mode});
    npc = br ? tg : (we && ws == 4'd15) ? wv[25:2] : fa ? m_pc + 24'd1 : m_pc;
    @(posedge clk);
    if (we && ws != 4'd15) put(m_mode, ws, wv);
    if (br && bl) put(m_mode, 14, {6'b0, m_pc + 24'd1, 2'b00}); // R9 link wins
    if (we && ws == 4'd15) begin
      m_flags = wv[31:28]; m_dis = wv[27:26]; m_mode = wv[1:0];
    end
    m_pc = npc;
  endtask

  task automatic set_mode(input logic [1:0] md);
    step(1, 15, {m_flags, m_dis, m_pc, md}, 0, 0, 0, 0, 0, 15, "R10");
  endtask

  task automatic idle_read(input logic [3:0] ra, input logic [3:0] rb, input string req);
    step(0, 0, 0, 0, 0, 0, 0, ra, rb, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=hang expected=finish");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 4; m++) for (int i = 0; i < 15; i++) view[m][i] = 0;
    m_pc = 0; m_flags = 0; m_dis = 2'b11; m_mode = 2'b11;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset image
    idle_read(15, 13, "R1");
    check("R1", rd_a_val, 32'h0C000003);
    idle_read(0, 14, "R1");

    // R3: distinct fill per mode
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      for (int i = 0; i < 15; i++)
        step(1, 4'(i), {4'(m), 4'(i), 24'($urandom)}, 0, 0, 0, 0, 4'(i), 15, "R3");
    end
    // R4 R5 R6: readback per mode
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      for (int i = 0; i < 8; i++)  idle_read(4'(i), 4'(i), "R4");
      for (int i = 8; i < 13; i++) idle_read(4'(i), 4'(i), "R5");
      idle_read(13, 14, "R6");
    end

    // R7: wrap from all ones
    step(1, 15, {4'h5, 2'b01, 24'hFFFFFF, 2'b00}, 0, 0, 0, 0, 15, 15, "R10");
    step(0, 0, 0, 1, 0, 0, 0, 15, 15, "R7");
    idle_read(15, 15, "R7");
    check("R7", {8'h0, pc_word}, 32'h0);
    // R8: branch beats fetch
    step(0, 0, 0, 1, 1, 0, 24'h123456, 15, 0, "R8");
    idle_read(15, 15, "R8");
    check("R8", {8'h0, pc_word}, 32'h00123456);
    // R9: link collides with port write to slot 14 in IRQ mode
    set_mode(2'd2);
    step(1, 14, 32'hDEADBEEF, 0, 1, 1, 24'h000100, 14, 13, "R9");
    idle_read(14, 15, "R9");
    check("R9", rd_a_val, {6'b0, 24'h123457, 2'b00});
    // R10: branch with status write, branch keeps PC
    step(1, 15, {4'hA, 2'b10, 24'h00FFFF, 2'b01}, 1, 1, 0, 24'h000777, 15, 15, "R10");
    idle_read(15, 8, "R10");
    check("R10", rd_a_val, {4'hA, 2'b10, 24'h000777, 2'b01});

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic we, br;
      we = ($urandom % 10) < 6;
      br = ($urandom % 10) == 0;
      step(we, 4'($urandom), $urandom, 1'($urandom), br, 1'($urandom),
           24'($urandom), 4'($urandom), 4'($urandom), "R2");
    end
    finish_run();
  end
endmodule